// File: doc/BRIEF.md
# Subset RISC Instruction Decode Stage

This block turns one 32-bit instruction word of a three-format load/store instruction subset into the fields and controls that the rest of a pipeline needs. The formats are register (R), immediate (I) and jump (J). The outputs are the source register indices, the shift amount, the 26-bit jump target, and a 32-bit immediate that is already extended the way the opcode asks. Alongside these come the ALU operation, the ALU operand-B source, the register-write enable and destination index, the memory read and write strobes, the branch and jump kinds, a multiply/divide unit command, and an illegal-instruction flag.

The opcode and function tables are decoded combinationally. The result is captured in one output register, so every output shows the decode of the word presented one clock earlier. The register file, the ALU itself, data memory and the next-PC adder sit outside and consume these outputs.

Top module: `rsd_decode_top`

## Requirements
- R1: The outputs `rs_idx` (bits 25:21), `rt_idx` (bits 20:16), `shamt` (bits 10:6) and `jump_tgt` (bits 25:0) carry the fields of the instruction sampled at the previous rising clock edge.
- R2: `imm_ext` holds the 16-bit field (bits 15:0) zero-extended for opcodes 0x09, 0x0C, 0x0D and 0x0E. For opcode 0x0F it holds the field in bits 31:16 with bits 15:0 zero. For every other word, including illegal ones, it holds the field sign-extended.
- R3: Opcode 0 takes its operation from func (bits 5:0). The `alu_op` codes are ADD=0, SUB=1, AND=2, OR=3, XOR=4, NOR=5, SLT=6, SLTU=7, SLL=8, SRL=9, SRA=10 and PASSB=11. The funcs map as follows: 0x20 and 0x21 to ADD, 0x22 and 0x23 to SUB, 0x24 to AND, 0x25 to OR, 0x26 to XOR, 0x27 to NOR, 0x2A to SLT and 0x2B to SLTU. Funcs 0x00 and 0x04 map to SLL, 0x02 and 0x06 to SRL, and 0x03 and 0x07 to SRA. `shift_by_reg` is 1 only for 0x04, 0x06 and 0x07. `alu_src_imm` is 0 for every R-type word.
- R4: I-type opcodes set `alu_src_imm`=1 and map as follows: 0x08, 0x09, 0x23 and 0x2B to ADD, 0x0A to SLT, 0x0B to SLTU, 0x0C to AND, 0x0D to OR, 0x0E to XOR and 0x0F to PASSB. Branches 0x04 and 0x05 use SUB with `alu_src_imm`=0. J-type and legal words not named here give ADD with `alu_src_imm`=0.
- R5: The destination index `reg_dst` is chosen as follows: rt for the writing I-type opcodes (0x08 to 0x0F and 0x23), rd (bits 15:11) for R-type arithmetic, logic, shift, jalr (func 0x09), mfhi (func 0x10) and mflo (func 0x12), and 31 for jal (opcode 3). `link_wr` is 1 for jal and jalr. `reg_dst` is 0 for words that do not write a register.
- R6: `reg_we` is 1 exactly when the word writes a register and its destination index is not 0.
- R7: `mem_rd` is 1 only for opcode 0x23 and `mem_wr` only for opcode 0x2B. The two are never both 1.
- R8: `branch_kind` is 1 for opcode 0x04 (equal), 2 for 0x05 (not equal) and otherwise 0. `jump_kind` is 1 for opcodes 2 and 3 (target), 2 for funcs 0x08 and 0x09 under opcode 0 (register) and otherwise 0. Neither a branch nor a jump other than a linking one writes a register.
- R9: `md_cmd` is 1 for mult (func 0x18), 2 for multu (0x19), 3 for div (0x1A), 4 for divu (0x1B), 5 for mfhi (0x10), 6 for mflo (0x12) and otherwise 0.
- R10: An opcode or func not listed above sets `illegal`. All control outputs (`alu_op`, `alu_src_imm`, `shift_by_reg`, `reg_we`, `reg_dst`, `link_wr`, `mem_rd`, `mem_wr`, `branch_kind`, `jump_kind`, `md_cmd`) are then 0.
- R11: While `rst_n` is sampled low at a rising edge, every output becomes 0 at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr | input | 32 | Instruction word to decode |
| rs_idx | output | 5 | First source register index |
| rt_idx | output | 5 | Second source register index |
| shamt | output | 5 | Constant shift amount |
| jump_tgt | output | 26 | Jump target field |
| imm_ext | output | 32 | Extended immediate |
| alu_op | output | 4 | ALU operation code |
| alu_src_imm | output | 1 | ALU operand B comes from the immediate |
| shift_by_reg | output | 1 | Shift amount comes from a register |
| reg_we | output | 1 | Register file write enable |
| reg_dst | output | 5 | Register file write index |
| link_wr | output | 1 | Written value is the return address |
| mem_rd | output | 1 | Data memory word read |
| mem_wr | output | 1 | Data memory word write |
| branch_kind | output | 2 | 0 none, 1 equal, 2 not equal |
| jump_kind | output | 2 | 0 none, 1 target, 2 register |
| md_cmd | output | 3 | Multiply/divide unit command |
| illegal | output | 1 | Unlisted opcode or func |

## Verification
The corner cases the bench aims at are these:
- Immediates with bit 15 set under each extension mode. A design that picked the wrong mode per opcode would show ones or zeros in the upper half that the other mode forbids. In particular, unsigned add-immediate or set-less-than-unsigned-immediate in the wrong mode would shift arithmetic results by 0xFFFF0000.
- Writes aimed at register 0 for rt, rd and jalr destinations. A design without suppression would assert `reg_we` and corrupt the hard-wired zero.
- The funcs that sit next to legal codes (0x01, 0x05, 0x11, 0x28) and opcodes such as 0x01, 0x20 and 0x3F. A loose decode would treat these as legal and leave a write or memory strobe on.
- jal against jalr. The first must force index 31 and the second must honour rd.

// File: rtl/rsd_pkg.sv
// Package rsd_pkg
// Shared encodings for the subset instruction decoder: field widths,
// opcode and function codes, and the decoded control record.
// Assumes a 32-bit instruction word with a 6-bit opcode at the top.
package rsd_pkg;

    localparam int unsigned INSN_W  = 32;
    localparam int unsigned OPC_W   = 6;
    localparam int unsigned FN_W    = 6;
    localparam int unsigned RIDX_W  = 5;
    localparam int unsigned IMM_W   = 16;
    localparam int unsigned JT_W    = 26;

    // Opcode values (those the decoder accepts)
    localparam logic [OPC_W-1:0] OPC_SPECIAL = 6'h00;
    localparam logic [OPC_W-1:0] OPC_J       = 6'h02;
    localparam logic [OPC_W-1:0] OPC_JAL     = 6'h03;
    localparam logic [OPC_W-1:0] OPC_BEQ     = 6'h04;
    localparam logic [OPC_W-1:0] OPC_BNE     = 6'h05;
    localparam logic [OPC_W-1:0] OPC_ADDI    = 6'h08;
    localparam logic [OPC_W-1:0] OPC_ADDIU   = 6'h09;
    localparam logic [OPC_W-1:0] OPC_SLTI    = 6'h0A;
    localparam logic [OPC_W-1:0] OPC_SLTIU   = 6'h0B;
    localparam logic [OPC_W-1:0] OPC_ANDI    = 6'h0C;
    localparam logic [OPC_W-1:0] OPC_ORI     = 6'h0D;
    localparam logic [OPC_W-1:0] OPC_XORI    = 6'h0E;
    localparam logic [OPC_W-1:0] OPC_LUI     = 6'h0F;
    localparam logic [OPC_W-1:0] OPC_LW      = 6'h23;
    localparam logic [OPC_W-1:0] OPC_SW      = 6'h2B;

    // Function values under OPC_SPECIAL
    localparam logic [FN_W-1:0] FN_SLL   = 6'h00;
    localparam logic [FN_W-1:0] FN_SRL   = 6'h02;
    localparam logic [FN_W-1:0] FN_SRA   = 6'h03;
    localparam logic [FN_W-1:0] FN_SLLV  = 6'h04;
    localparam logic [FN_W-1:0] FN_SRLV  = 6'h06;
    localparam logic [FN_W-1:0] FN_SRAV  = 6'h07;
    localparam logic [FN_W-1:0] FN_JR    = 6'h08;
    localparam logic [FN_W-1:0] FN_JALR  = 6'h09;
    localparam logic [FN_W-1:0] FN_MFHI  = 6'h10;
    localparam logic [FN_W-1:0] FN_MFLO  = 6'h12;
    localparam logic [FN_W-1:0] FN_MULT  = 6'h18;
    localparam logic [FN_W-1:0] FN_MULTU = 6'h19;
    localparam logic [FN_W-1:0] FN_DIV   = 6'h1A;
    localparam logic [FN_W-1:0] FN_DIVU  = 6'h1B;
    localparam logic [FN_W-1:0] FN_ADD   = 6'h20;
    localparam logic [FN_W-1:0] FN_ADDU  = 6'h21;
    localparam logic [FN_W-1:0] FN_SUB   = 6'h22;
    localparam logic [FN_W-1:0] FN_SUBU  = 6'h23;
    localparam logic [FN_W-1:0] FN_AND   = 6'h24;
    localparam logic [FN_W-1:0] FN_OR    = 6'h25;
    localparam logic [FN_W-1:0] FN_XOR   = 6'h26;
    localparam logic [FN_W-1:0] FN_NOR   = 6'h27;
    localparam logic [FN_W-1:0] FN_SLT   = 6'h2A;
    localparam logic [FN_W-1:0] FN_SLTU  = 6'h2B;

    typedef enum logic [3:0] {
        ALU_ADD   = 4'd0,
        ALU_SUB   = 4'd1,
        ALU_AND   = 4'd2,
        ALU_OR    = 4'd3,
        ALU_XOR   = 4'd4,
        ALU_NOR   = 4'd5,
        ALU_SLT   = 4'd6,
        ALU_SLTU  = 4'd7,
        ALU_SLL   = 4'd8,
        ALU_SRL   = 4'd9,
        ALU_SRA   = 4'd10,
        ALU_PASSB = 4'd11
    } alu_op_e;

    typedef enum logic [1:0] {
        BR_NONE = 2'd0,
        BR_EQ   = 2'd1,
        BR_NE   = 2'd2
    } br_kind_e;

    typedef enum logic [1:0] {
        JMP_NONE = 2'd0,
        JMP_TGT  = 2'd1,
        JMP_REG  = 2'd2
    } jmp_kind_e;

    typedef enum logic [2:0] {
        MD_NONE  = 3'd0,
        MD_MULT  = 3'd1,
        MD_MULTU = 3'd2,
        MD_DIV   = 3'd3,
        MD_DIVU  = 3'd4,
        MD_MFHI  = 3'd5,
        MD_MFLO  = 3'd6
    } md_cmd_e;

    typedef enum logic [1:0] {
        EXT_SIGN  = 2'd0,
        EXT_ZERO  = 2'd1,
        EXT_UPPER = 2'd2
    } ext_mode_e;

    typedef enum logic [1:0] {
        DST_NONE = 2'd0,
        DST_RT   = 2'd1,
        DST_RD   = 2'd2,
        DST_LINK = 2'd3
    } dst_sel_e;

    typedef struct packed {
        alu_op_e   alu_op;
        logic      alu_src_imm;
        logic      shift_by_reg;
        dst_sel_e  dst_sel;
        logic      link_wr;
        logic      mem_rd;
        logic      mem_wr;
        br_kind_e  branch_kind;
        jmp_kind_e jump_kind;
        md_cmd_e   md_cmd;
        ext_mode_e ext_mode;
        logic      illegal;
    } ctrl_t;

endpackage

// File: rtl/rsd_ctrl.sv
// Module rsd_ctrl
// Combinational opcode/func table. Produces the control record for one
// instruction; an unlisted code yields a record with only illegal set.
// Assumes the caller supplies the opcode and func fields already split.
module rsd_ctrl
    import rsd_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    input  logic [FN_W-1:0]  func,
    output ctrl_t            ctrl
);

    ctrl_t raw;

    // Decode func when opcode is zero
    function automatic ctrl_t dec_special(input logic [FN_W-1:0] fn);
        ctrl_t c;
        c = '0;
        c.ext_mode = EXT_SIGN;
        case (fn)
            FN_ADD, FN_ADDU: begin c.alu_op = ALU_ADD;  c.dst_sel = DST_RD; end
            FN_SUB, FN_SUBU: begin c.alu_op = ALU_SUB;  c.dst_sel = DST_RD; end
            FN_AND:          begin c.alu_op = ALU_AND;  c.dst_sel = DST_RD; end
            FN_OR:           begin c.alu_op = ALU_OR;   c.dst_sel = DST_RD; end
            FN_XOR:          begin c.alu_op = ALU_XOR;  c.dst_sel = DST_RD; end
            FN_NOR:          begin c.alu_op = ALU_NOR;  c.dst_sel = DST_RD; end
            FN_SLT:          begin c.alu_op = ALU_SLT;  c.dst_sel = DST_RD; end
            FN_SLTU:         begin c.alu_op = ALU_SLTU; c.dst_sel = DST_RD; end
            FN_SLL:          begin c.alu_op = ALU_SLL;  c.dst_sel = DST_RD; end
            FN_SRL:          begin c.alu_op = ALU_SRL;  c.dst_sel = DST_RD; end
            FN_SRA:          begin c.alu_op = ALU_SRA;  c.dst_sel = DST_RD; end
            FN_SLLV: begin
                c.alu_op = ALU_SLL; c.shift_by_reg = 1'b1; c.dst_sel = DST_RD;
            end
            FN_SRLV: begin
                c.alu_op = ALU_SRL; c.shift_by_reg = 1'b1; c.dst_sel = DST_RD;
            end
            FN_SRAV: begin
                c.alu_op = ALU_SRA; c.shift_by_reg = 1'b1; c.dst_sel = DST_RD;
            end
            FN_JR:    c.jump_kind = JMP_REG;
            FN_JALR: begin
                c.jump_kind = JMP_REG; c.link_wr = 1'b1; c.dst_sel = DST_RD;
            end
            FN_MULT:  c.md_cmd = MD_MULT;
            FN_MULTU: c.md_cmd = MD_MULTU;
            FN_DIV:   c.md_cmd = MD_DIV;
            FN_DIVU:  c.md_cmd = MD_DIVU;
            FN_MFHI: begin c.md_cmd = MD_MFHI; c.dst_sel = DST_RD; end
            FN_MFLO: begin c.md_cmd = MD_MFLO; c.dst_sel = DST_RD; end
            default:  c.illegal = 1'b1;
        endcase
        return c;
    endfunction

    // Build an I-type ALU record writing rt
    function automatic ctrl_t imm_alu(input alu_op_e op, input ext_mode_e ext);
        ctrl_t c;
        c = '0;
        c.alu_op      = op;
        c.alu_src_imm = 1'b1;
        c.dst_sel     = DST_RT;
        c.ext_mode    = ext;
        return c;
    endfunction

    // Main opcode table
    always_comb begin
        raw = '0;
        case (opcode)
            OPC_SPECIAL: raw = dec_special(func);
            OPC_J:       raw.jump_kind = JMP_TGT;
            OPC_JAL: begin
                raw.jump_kind = JMP_TGT;
                raw.link_wr   = 1'b1;
                raw.dst_sel   = DST_LINK;
            end
            OPC_BEQ: begin raw.alu_op = ALU_SUB; raw.branch_kind = BR_EQ; end
            OPC_BNE: begin raw.alu_op = ALU_SUB; raw.branch_kind = BR_NE; end
            OPC_ADDI:  raw = imm_alu(ALU_ADD,   EXT_SIGN);
            OPC_ADDIU: raw = imm_alu(ALU_ADD,   EXT_ZERO);
            OPC_SLTI:  raw = imm_alu(ALU_SLT,   EXT_SIGN);
            OPC_SLTIU: raw = imm_alu(ALU_SLTU,  EXT_SIGN);
            OPC_ANDI:  raw = imm_alu(ALU_AND,   EXT_ZERO);
            OPC_ORI:   raw = imm_alu(ALU_OR,    EXT_ZERO);
            OPC_XORI:  raw = imm_alu(ALU_XOR,   EXT_ZERO);
            OPC_LUI:   raw = imm_alu(ALU_PASSB, EXT_UPPER);
            OPC_LW: begin
                raw = imm_alu(ALU_ADD, EXT_SIGN);
                raw.mem_rd = 1'b1;
            end
            OPC_SW: begin
                raw = imm_alu(ALU_ADD, EXT_SIGN);
                raw.dst_sel = DST_NONE;
                raw.mem_wr  = 1'b1;
            end
            default: raw.illegal = 1'b1;
        endcase
    end

    // Quiet every control when the code is not recognised
    always_comb begin
        ctrl = raw;
        if (raw.illegal) begin
            ctrl         = '0;
            ctrl.illegal = 1'b1;
        end
    end

endmodule

// File: rtl/rsd_imm_ext.sv
// Module rsd_imm_ext
// Widens the immediate field to the data width by sign extension, zero
// extension, or placement in the upper half. Assumes DATA_W > IMM_LEN.
module rsd_imm_ext
    import rsd_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned IMM_LEN = IMM_W
) (
    input  logic [IMM_LEN-1:0] imm,
    input  ext_mode_e          mode,
    output logic [DATA_W-1:0]  ext
);

    localparam int unsigned PAD = DATA_W - IMM_LEN;

    logic [DATA_W-1:0] sext;
    logic [DATA_W-1:0] zext;
    logic [DATA_W-1:0] upper;

    // Candidate forms of the constant
    always_comb begin
        sext  = {{PAD{imm[IMM_LEN-1]}}, imm};
        zext  = {{PAD{1'b0}}, imm};
        upper = zext << IMM_LEN;
    end

    // Pick the form the opcode asked for
    always_comb begin
        case (mode)
            EXT_ZERO:  ext = zext;
            EXT_UPPER: ext = upper;
            default:   ext = sext;
        endcase
    end

endmodule

// File: rtl/rsd_dst_sel.sv
// Module rsd_dst_sel
// Chooses the register write index from rt, rd or the fixed link register
// and drops the write enable when the chosen index is register zero.
module rsd_dst_sel
    import rsd_pkg::*;
#(
    parameter int unsigned IDX_W    = RIDX_W,
    parameter int unsigned LINK_REG = 31
) (
    input  dst_sel_e         sel,
    input  logic [IDX_W-1:0] rt,
    input  logic [IDX_W-1:0] rd,
    output logic [IDX_W-1:0] dst,
    output logic             we
);

    localparam logic [IDX_W-1:0] LINK_IDX = IDX_W'(LINK_REG);

    // Index multiplexer
    always_comb begin
        case (sel)
            DST_RT:   dst = rt;
            DST_RD:   dst = rd;
            DST_LINK: dst = LINK_IDX;
            default:  dst = '0;
        endcase
    end

    // Write enable, suppressed for the zero register
    always_comb begin
        we = (sel != DST_NONE) && (dst != '0);
    end

endmodule

// File: rtl/rsd_decode_top.sv
// Module rsd_decode_top
// Decode stage for the three-format instruction subset: splits fields,
// decodes controls, extends the immediate and registers the lot, so each
// output reflects the word sampled one rising edge earlier.
// Assumes a synchronous active-low reset that clears every output.
module rsd_decode_top
    import rsd_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned LINK_REG = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       instr,
    output logic [4:0]        rs_idx,
    output logic [4:0]        rt_idx,
    output logic [4:0]        shamt,
    output logic [25:0]       jump_tgt,
    output logic [DATA_W-1:0] imm_ext,
    output logic [3:0]        alu_op,
    output logic              alu_src_imm,
    output logic              shift_by_reg,
    output logic              reg_we,
    output logic [4:0]        reg_dst,
    output logic              link_wr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [1:0]        branch_kind,
    output logic [1:0]        jump_kind,
    output logic [2:0]        md_cmd,
    output logic              illegal
);

    localparam int unsigned OPC_LSB = INSN_W - OPC_W;
    localparam int unsigned RS_LSB  = OPC_LSB - RIDX_W;
    localparam int unsigned RT_LSB  = RS_LSB - RIDX_W;
    localparam int unsigned RD_LSB  = RT_LSB - RIDX_W;
    localparam int unsigned SH_LSB  = RD_LSB - RIDX_W;

    logic [OPC_W-1:0]  f_opc;
    logic [FN_W-1:0]   f_fn;
    logic [RIDX_W-1:0] f_rs, f_rt, f_rd, f_sh;
    logic [IMM_W-1:0]  f_imm;
    logic [JT_W-1:0]   f_jt;

    ctrl_t             ctrl;
    logic [DATA_W-1:0] imm_d;
    logic [RIDX_W-1:0] dst_d;
    logic              we_d;

    // Field split
    always_comb begin
        f_opc = instr[INSN_W-1:OPC_LSB];
        f_rs  = instr[OPC_LSB-1:RS_LSB];
        f_rt  = instr[RS_LSB-1:RT_LSB];
        f_rd  = instr[RT_LSB-1:RD_LSB];
        f_sh  = instr[RD_LSB-1:SH_LSB];
        f_fn  = instr[FN_W-1:0];
        f_imm = instr[IMM_W-1:0];
        f_jt  = instr[JT_W-1:0];
    end

    rsd_ctrl u_ctrl (
        .opcode (f_opc),
        .func   (f_fn),
        .ctrl   (ctrl)
    );

    rsd_imm_ext #(
        .DATA_W  (DATA_W),
        .IMM_LEN (IMM_W)
    ) u_imm (
        .imm  (f_imm),
        .mode (ctrl.ext_mode),
        .ext  (imm_d)
    );

    rsd_dst_sel #(
        .IDX_W    (RIDX_W),
        .LINK_REG (LINK_REG)
    ) u_dst (
        .sel (ctrl.dst_sel),
        .rt  (f_rt),
        .rd  (f_rd),
        .dst (dst_d),
        .we  (we_d)
    );

    // Output register of the decode stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs_idx       <= '0;
            rt_idx       <= '0;
            shamt        <= '0;
            jump_tgt     <= '0;
            imm_ext      <= '0;
            alu_op       <= '0;
            alu_src_imm  <= 1'b0;
            shift_by_reg <= 1'b0;
            reg_we       <= 1'b0;
            reg_dst      <= '0;
            link_wr      <= 1'b0;
            mem_rd       <= 1'b0;
            mem_wr       <= 1'b0;
            branch_kind  <= '0;
            jump_kind    <= '0;
            md_cmd       <= '0;
            illegal      <= 1'b0;
        end else begin
            rs_idx       <= f_rs;
            rt_idx       <= f_rt;
            shamt        <= f_sh;
            jump_tgt     <= f_jt;
            imm_ext      <= imm_d;
            alu_op       <= ctrl.alu_op;
            alu_src_imm  <= ctrl.alu_src_imm;
            shift_by_reg <= ctrl.shift_by_reg;
            reg_we       <= we_d;
            reg_dst      <= dst_d;
            link_wr      <= ctrl.link_wr;
            mem_rd       <= ctrl.mem_rd;
            mem_wr       <= ctrl.mem_wr;
            branch_kind  <= ctrl.branch_kind;
            jump_kind    <= ctrl.jump_kind;
            md_cmd       <= ctrl.md_cmd;
            illegal      <= ctrl.illegal;
        end
    end

    // R6: a registered write never targets register zero
    a_r6_no_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (reg_dst != '0));

    // R10: an illegal word leaves every control quiet
    a_r10_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!reg_we && !mem_rd && !mem_wr && !link_wr &&
                     branch_kind == '0 && jump_kind == '0 && md_cmd == '0));

    // R7: read and write strobes are exclusive
    a_r7_one_mem_op: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R8: a branch writes no register and is not also a jump
    a_r8_branch_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (branch_kind != '0) |-> (!reg_we && jump_kind == '0));

    // R5: a linking target jump writes the link register
    a_r5_jal_link_reg: assert property (@(posedge clk) disable iff (!rst_n)
        (jump_kind == JMP_TGT && link_wr) |->
            (reg_we && reg_dst == RIDX_W'(LINK_REG)));

    // R2: load-upper places the field high with a zero low half
    a_r2_lui_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[INSN_W-1:OPC_LSB] == OPC_LUI) |=>
            (imm_ext[IMM_W-1:0] == '0 &&
             imm_ext[2*IMM_W-1:IMM_W] == $past(instr[IMM_W-1:0])));

    // R11: reset clears the decode outputs on the next edge
    a_r11_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!reg_we && !mem_rd && !mem_wr && !illegal && imm_ext == '0));

endmodule

// File: tb/rsd_decode_top_tb.sv
// Bench for rsd_decode_top: a behavioural reference computes the expected
// outputs of each word and compares them one clock later, every clock.
module rsd_decode_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = 32'h0;

    logic [4:0]  rs_idx, rt_idx, shamt, reg_dst;
    logic [25:0] jump_tgt;
    logic [31:0] imm_ext;
    logic [3:0]  alu_op;
    logic        alu_src_imm, shift_by_reg, reg_we, link_wr, mem_rd, mem_wr, illegal;
    logic [1:0]  branch_kind, jump_kind;
    logic [2:0]  md_cmd;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    rsd_decode_top u_dut (
        .clk(clk), .rst_n(rst_n), .instr(instr),
        .rs_idx(rs_idx), .rt_idx(rt_idx), .shamt(shamt), .jump_tgt(jump_tgt),
        .imm_ext(imm_ext), .alu_op(alu_op), .alu_src_imm(alu_src_imm),
        .shift_by_reg(shift_by_reg), .reg_we(reg_we), .reg_dst(reg_dst),
        .link_wr(link_wr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .branch_kind(branch_kind), .jump_kind(jump_kind), .md_cmd(md_cmd),
        .illegal(illegal)
    );

    typedef struct {
        logic [31:0] imm;
        int alu, aimm, svar, we, dst, link, mrd, mwr, br, jk, md, ill;
    } exp_t;

    // Reference decode written from the requirements
    function automatic exp_t model(input logic [31:0] w);
        exp_t e;
        int op, fn, dsel, ext;
        op = int'(w[31:26]);
        fn = int'(w[5:0]);
        e = '{imm: 32'h0, default: 0};
        dsel = 0; ext = 0;
        if (op == 0) begin
            dsel = 2;
            case (fn)
                32, 33: e.alu = 0;
                34, 35: e.alu = 1;
                36: e.alu = 2;
                37: e.alu = 3;
                38: e.alu = 4;
                39: e.alu = 5;
                42: e.alu = 6;
                43: e.alu = 7;
                0: e.alu = 8;
                2: e.alu = 9;
                3: e.alu = 10;
                4: begin e.alu = 8;  e.svar = 1; end
                6: begin e.alu = 9;  e.svar = 1; end
                7: begin e.alu = 10; e.svar = 1; end
                8: begin e.jk = 2; dsel = 0; end
                9: begin e.jk = 2; e.link = 1; end
                24: begin e.md = 1; dsel = 0; end
                25: begin e.md = 2; dsel = 0; end
                26: begin e.md = 3; dsel = 0; end
                27: begin e.md = 4; dsel = 0; end
                16: e.md = 5;
                18: e.md = 6;
                default: e.ill = 1;
            endcase
        end else begin
            case (op)
                2: e.jk = 1;
                3: begin e.jk = 1; e.link = 1; dsel = 3; end
                4: begin e.br = 1; e.alu = 1; end
                5: begin e.br = 2; e.alu = 1; end
                8:  begin e.aimm = 1; dsel = 1; end
                9:  begin e.aimm = 1; dsel = 1; ext = 1; end
                10: begin e.aimm = 1; dsel = 1; e.alu = 6; end
                11: begin e.aimm = 1; dsel = 1; e.alu = 7; end
                12: begin e.aimm = 1; dsel = 1; e.alu = 2; ext = 1; end
                13: begin e.aimm = 1; dsel = 1; e.alu = 3; ext = 1; end
                14: begin e.aimm = 1; dsel = 1; e.alu = 4; ext = 1; end
                15: begin e.aimm = 1; dsel = 1; e.alu = 11; ext = 2; end
                35: begin e.aimm = 1; dsel = 1; e.mrd = 1; end
                43: begin e.aimm = 1; e.mwr = 1; end
                default: e.ill = 1;
            endcase
        end
        if (e.ill == 1) begin
            e = '{imm: 32'h0, default: 0};
            e.ill = 1;
            dsel = 0; ext = 0;
        end
        case (dsel)
            1: e.dst = int'(w[20:16]);
            2: e.dst = int'(w[15:11]);
            3: e.dst = 31;
            default: e.dst = 0;
        endcase
        e.we = (dsel != 0 && e.dst != 0) ? 1 : 0;
        if (ext == 1)      e.imm = {16'h0, w[15:0]};
        else if (ext == 2) e.imm = {w[15:0], 16'h0};
        else               e.imm = {{16{w[15]}}, w[15:0]};
        return e;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic compare(input logic [31:0] w);
        exp_t e;
        string rq;
        e = model(w);
        rq = (w[31:26] == 6'h0) ? "R3" : "R4";
        chk("R1", "rs_idx", int'(rs_idx), int'(w[25:21]));
        chk("R1", "rt_idx", int'(rt_idx), int'(w[20:16]));
        chk("R1", "shamt", int'(shamt), int'(w[10:6]));
        chk("R1", "jump_tgt", int'(jump_tgt), int'(w[25:0]));
        chk("R2", "imm_ext", int'(imm_ext), int'(e.imm));
        chk(rq, "alu_op", int'(alu_op), e.alu);
        chk(rq, "alu_src_imm", int'(alu_src_imm), e.aimm);
        chk("R3", "shift_by_reg", int'(shift_by_reg), e.svar);
        chk("R5", "reg_dst", int'(reg_dst), e.dst);
        chk("R5", "link_wr", int'(link_wr), e.link);
        chk("R6", "reg_we", int'(reg_we), e.we);
        chk("R7", "mem_rd", int'(mem_rd), e.mrd);
        chk("R7", "mem_wr", int'(mem_wr), e.mwr);
        chk("R8", "branch_kind", int'(branch_kind), e.br);
        chk("R8", "jump_kind", int'(jump_kind), e.jk);
        chk("R9", "md_cmd", int'(md_cmd), e.md);
        chk("R10", "illegal", int'(illegal), e.ill);
    endtask

    // R11: every output zero while in reset
    task automatic check_reset_state();
        chk("R11", "outputs_or", int'(|{rs_idx, rt_idx, shamt, jump_tgt, imm_ext,
            alu_op, alu_src_imm, shift_by_reg, reg_we, reg_dst, link_wr,
            mem_rd, mem_wr, branch_kind, jump_kind, md_cmd, illegal}), 0);
    endtask

    logic [31:0] prev_w;
    bit          have_prev = 0;

    // One clock: check the previous word, then present a new one
    task automatic step(input logic [31:0] w);
        @(negedge clk);
        if (have_prev) compare(prev_w);
        instr = w;
        prev_w = w;
        have_prev = rst_n;
    endtask

    function automatic logic [31:0] rtype(input int rs, rt, rd, sh, fn);
        return {6'h0, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
    endfunction

    function automatic logic [31:0] itype(input int op, rs, rt, imm);
        return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    initial begin
        int legal_op[17] = '{0,0,0,2,3,4,5,8,9,10,11,12,13,14,15,35,43};
        int legal_fn[24] = '{0,2,3,4,6,7,8,9,16,18,24,25,26,27,32,33,34,35,36,37,38,39,42,43};
        logic [31:0] w;

        // R11: reset with busy input
        instr = itype(35, 3, 7, 16'h8004);
        repeat (2) @(negedge clk);
        check_reset_state();
        rst_n = 1'b1;
        prev_w = instr;
        have_prev = 1;

        // R2: extension modes with bit 15 set and clear
        step(itype(8, 1, 2, 16'hFFFD));
        step(itype(9, 1, 2, 16'hFFFD));
        step(itype(11, 1, 2, 16'h8000));
        step(itype(12, 1, 2, 16'h8723));
        step(itype(13, 5, 5, 16'hABCD));
        step(itype(14, 2, 1, 16'hFF12));
        step(itype(15, 0, 5, 16'h5678));
        step(itype(10, 4, 6, 16'h7FFF));
        // R7 memory, R8 branches
        step(itype(35, 0, 8, 16'h1008));
        step(itype(43, 0, 8, 16'h100C));
        step(itype(4, 3, 4, 16'hFFFF));
        step(itype(5, 3, 4, 16'h0019));
        // R5 links and R8 jumps
        step({6'd2, 26'h3ABCDEF});
        step({6'd3, 26'h0000271});
        step(rtype(8, 0, 0, 0, 8));
        step(rtype(8, 0, 31, 0, 9));
        step(rtype(8, 0, 0, 0, 9));
        // R6: writes aimed at register zero
        step(itype(8, 3, 0, 16'h0001));
        step(rtype(1, 2, 0, 0, 32));
        step(32'h0000_0000);
        step(itype(35, 1, 0, 16'h0000));
        // R3 shifts and arithmetic, R9 multiply/divide
        step(rtype(0, 9, 10, 4, 0));
        step(rtype(0, 9, 10, 31, 3));
        step(rtype(11, 9, 10, 0, 7));
        step(rtype(2, 3, 1, 0, 39));
        step(rtype(2, 3, 1, 0, 43));
        step(rtype(2, 3, 0, 0, 26));
        step(rtype(0, 0, 12, 0, 16));
        step(rtype(0, 0, 13, 0, 18));
        // R10: neighbours of legal codes
        step(rtype(2, 3, 4, 0, 1));
        step(rtype(2, 3, 4, 0, 5));
        step(rtype(2, 3, 4, 0, 17));
        step(rtype(2, 3, 4, 0, 40));
        step(itype(1, 2, 3, 16'h8000));
        step(itype(32, 2, 3, 16'h0004));
        step(itype(63, 31, 31, 16'hFFFF));

        // Mixed stream biased towards legal codes
        for (int i = 0; i < 3000; i++) begin
            w = $urandom;
            if (($urandom % 4) != 0) begin
                w[31:26] = 6'(legal_op[$urandom % 17]);
                if (w[31:26] == 6'h0) w[5:0] = 6'(legal_fn[$urandom % 24]);
            end
            if (($urandom % 8) == 0) begin
                w[20:16] = 5'h0;
                w[15:11] = 5'h0;
            end
            step(w);
        end

        // R11: reset in mid-stream
        @(negedge clk);
        compare(prev_w);
        rst_n = 1'b0;
        instr = rtype(1, 2, 3, 0, 32);
        have_prev = 0;
        @(negedge clk);
        check_reset_state();
        rst_n = 1'b1;
        prev_w = instr;
        have_prev = 1;
        step(itype(3, 0, 0, 16'h0040));
        step(32'h0);
        @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule